// File: doc/BRIEF.md
# Gray-Scale PWM Dot Driver Gating

This block turns a row of dot requests into final driver enables for a print head. One gray-scale code is shared by all dots. A 4-bit counter advances on a counter tick and is compared against that code to open a shared on-time window. Codes 0 to 14 give an on-time of code/16 of the period, and code 15 keeps the window open for the whole period.

A separate off request decides whether the outputs may drive at all. It is sampled only on an enable strobe, which is an enable tick that a gate input lets through. Turn-on and turn-off therefore happen only at those edges. The host can shape the on-time by driving the request directly, or by choosing when it opens the gate. A programmable limit on the number of strobes can stop the outputs after a maximum on-time. An active-low asynchronous reset forces every output off and clears the counter.

The block runs on one system clock. The counter clock and the enable clock arrive as single-cycle tick inputs.

Top module: `grayPwmGate`

## Requirements
- R1: Each clock with `cntTick` high advances the PWM count by one. The count wraps from 15 to 0, so one PWM period is 16 ticks.
- R2: For codes 0 to 14, the window is open while the count is below `grayVal`. The duty is therefore grayVal/16, and code 0 never opens.
- R3: Code 15 keeps the window open at all 16 count values.
- R4: A strobe edge (`enTick` and `wrGate` both high) with `offReq` high turns all outputs off from that edge onward.
- R5: A strobe edge with `offReq` low turns the outputs on from that edge onward. A change of `offReq` between strobe edges has no effect on the outputs.
- R6: With `wrGate` low, `enTick` has no effect on the on/off state.
- R7: `drvEn[i]` is high exactly when `dotReq[i]` is 1, the outputs are on, and the window is open. Each dot is independent of the others.
- R8: While `rstN` is low, all outputs are off immediately. After reset the count starts at 0 and the outputs stay off until a turn-on strobe.
- R9: When `onLimit` is L > 0, the outputs are forced off at the L-th strobe after the turn-on strobe. They stay off until an off strobe is followed by a new turn-on strobe. L = 0 removes the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntTick | input | 1 | PWM counter advance tick |
| enTick | input | 1 | Enable clock tick |
| wrGate | input | 1 | Passes `enTick` when high |
| offReq | input | 1 | High requests outputs off, low requests on |
| grayVal | input | 4 | Latched gray-scale code |
| onLimit | input | 8 | Maximum on-time in strobes, 0 = no limit |
| dotReq | input | 48 | Dot data, 1 = dot wanted |
| drvEn | output | 48 | Final driver enables |

## Verification
The assertions assume that `grayVal`, `onLimit` and `dotReq` are steady data over the cycles they observe. They also assume that the turn-on property applies only when no limit is set, since a limit can close the gate on a strobe. The bench changes the code, the limit and the dot data only between strobes and ticks. It does so at mid-cycle, away from clock edges. The gray-scale sweep advances the counter through every value for every code, so the wrap and the full-on code are reached in order.

// File: rtl/grayPwmPkg.sv
package grayPwmPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntStep;  // advance PWM count this cycle
    logic outOpen;  // outputs allowed to drive
  } pwmCtl_t;
endpackage

// File: rtl/grayPwmCtl.sv
module grayPwmCtl
  import grayPwmPkg::*;
#(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cntTick,
  input  logic            enTick,
  input  logic            wrGate,
  input  logic            offReq,
  input  logic [LIMW-1:0] onLimit,
  output pwmCtl_t         ctl
);
  logic            strobe;
  logic            enActive;
  logic            expired;
  logic [LIMW-1:0] onCnt;
  logic [LIMW:0]   nextCnt;
  logic            limitOn;

  assign strobe  = enTick & wrGate;
  assign nextCnt = {1'b0, onCnt} + 1'b1;
  assign limitOn = (onLimit != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enActive <= 1'b0;
      expired  <= 1'b0;
      onCnt    <= '0;
    end else if (strobe) begin
      if (offReq) begin
        enActive <= 1'b0;
        expired  <= 1'b0;
        onCnt    <= '0;
      end else if (!enActive) begin
        enActive <= 1'b1;
        expired  <= 1'b0;
        onCnt    <= '0;
      end else if (!expired && limitOn) begin
        onCnt <= nextCnt[LIMW-1:0];
        if (nextCnt >= {1'b0, onLimit}) expired <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.cntStep = cntTick;
    ctl.outOpen = enActive & ~expired;
  end
endmodule

// File: rtl/grayPwmDp.sv
module grayPwmDp
  import grayPwmPkg::*;
#(
  parameter int NDOT = 48,
  parameter int GW   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  pwmCtl_t         ctl,
  input  logic [GW-1:0]   grayVal,
  input  logic [NDOT-1:0] dotReq,
  output logic [GW-1:0]   cntVal,
  output logic [NDOT-1:0] drvEn
);
  localparam logic [GW-1:0] FULLCODE = {GW{1'b1}};

  logic pwmWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else if (ctl.cntStep) cntVal <= cntVal + 1'b1;
  end

  assign pwmWin = (grayVal == FULLCODE) || (cntVal < grayVal);

  for (genvar i = 0; i < NDOT; i++) begin : g_dot
    assign drvEn[i] = dotReq[i] & ctl.outOpen & pwmWin;
  end
endmodule

// File: rtl/grayPwmGate.sv
module grayPwmGate
  import grayPwmPkg::*;
#(
  parameter int NDOT = 48,
  parameter int GW   = 4,
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cntTick,
  input  logic            enTick,
  input  logic            wrGate,
  input  logic            offReq,
  input  logic [GW-1:0]   grayVal,
  input  logic [LIMW-1:0] onLimit,
  input  logic [NDOT-1:0] dotReq,
  output logic [NDOT-1:0] drvEn
);
  pwmCtl_t       ctl;
  logic [GW-1:0] cntVal;
  logic          gateOn;

  assign gateOn = ctl.outOpen;

  grayPwmCtl #(.LIMW(LIMW)) ctl_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .enTick(enTick),
    .wrGate(wrGate), .offReq(offReq), .onLimit(onLimit), .ctl(ctl)
  );

  grayPwmDp #(.NDOT(NDOT), .GW(GW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .grayVal(grayVal),
    .dotReq(dotReq), .cntVal(cntVal), .drvEn(drvEn)
  );
endmodule

// File: rtl/grayPwmChk.sv
module grayPwmChk #(
  parameter int NDOT = 48,
  parameter int GW   = 4,
  parameter int LIMW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            cntTick,
  input logic            enTick,
  input logic            wrGate,
  input logic            offReq,
  input logic [GW-1:0]   grayVal,
  input logic [LIMW-1:0] onLimit,
  input logic [NDOT-1:0] dotReq,
  input logic [NDOT-1:0] drvEn,
  input logic [GW-1:0]   cntVal,
  input logic            gateOn
);
  localparam logic [GW-1:0] FULLCODE = {GW{1'b1}};

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cntTick |=> cntVal == $past(cntVal) + 1'b1); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntTick |=> $stable(cntVal)); // R1
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    grayVal == '0 |-> drvEn == '0); // R2
  AST_FULL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (grayVal == FULLCODE && gateOn) |-> drvEn == dotReq); // R3
  AST_TURN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (enTick && wrGate && offReq) |=> !gateOn); // R4
  AST_TURN_ON: assert property (@(posedge clk) disable iff (!rstN)
    (enTick && wrGate && !offReq && onLimit == '0) |=> gateOn); // R5
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !(enTick && wrGate) |=> $stable(gateOn)); // R6
  AST_DOT_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn & ~dotReq) == '0); // R7

  always @(posedge clk) begin
    if (!rstN) AST_RESET_OFF: assert (drvEn == '0); // R8
  end
endmodule

bind grayPwmGate grayPwmChk #(.NDOT(NDOT), .GW(GW), .LIMW(LIMW)) chk_i (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .enTick(enTick),
  .wrGate(wrGate), .offReq(offReq), .grayVal(grayVal), .onLimit(onLimit),
  .dotReq(dotReq), .drvEn(drvEn), .cntVal(cntVal), .gateOn(gateOn)
);

// File: tb/grayPwmGate_tb_top.sv
`timescale 1ns/1ps
module grayPwmGate_tb_top;
  localparam int NDOT = 48;
  localparam logic [NDOT-1:0] ONES = {NDOT{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0, enTick = 1'b0, wrGate = 1'b0, offReq = 1'b1;
  logic [3:0] grayVal = '0;
  logic [7:0] onLimit = '0;
  logic [NDOT-1:0] dotReq = '0;
  logic [NDOT-1:0] drvEn;

  int total = 0;
  int bad = 0;
  int mCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grayPwmGate dut_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .enTick(enTick),
    .wrGate(wrGate), .offReq(offReq), .grayVal(grayVal), .onLimit(onLimit),
    .dotReq(dotReq), .drvEn(drvEn)
  );

  task automatic chk(input string tag, input logic [NDOT-1:0] exp);
    total++;
    if (drvEn !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, drvEn, exp);
    end
  endtask

  // one clock edge, then settle mid-cycle
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic cntStep();
    cntTick = 1'b1; step(); cntTick = 1'b0;
    mCnt = (mCnt + 1) % 16;
  endtask

  task automatic strobe(input logic off);
    offReq = off; wrGate = 1'b1; enTick = 1'b1; step(); enTick = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    dotReq = ONES;
    step();
    chk("R8 reset off", '0);
    rstN = 1'b1;
    step();
    chk("R8 off until turn-on", '0);
    grayVal = 4'd15;
    strobe(1'b0);
    chk("R5 turn-on", ONES);

    // R1 R2 R3 exhaustive sweep
    for (int g = 0; g < 16; g++) begin
      grayVal = 4'(g);
      for (int c = 0; c < 16; c++) begin
        #1;
        if (g == 15) chk("R3 full code", ONES);
        else chk("R2/R1 window", (mCnt < g) ? ONES : '0);
        cntStep();
      end
    end

    // R7 dot independence
    for (int k = 0; k < 6; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      dotReq = r[NDOT-1:0];
      grayVal = 4'd15; #1;
      chk("R7 dots full", dotReq);
      grayVal = 4'd8; #1;
      chk("R7 dots window", (mCnt < 8) ? dotReq : '0);
      cntStep();
    end
    dotReq = ONES; grayVal = 4'd15;

    // R6 gate blocks strobe
    offReq = 1'b1; wrGate = 1'b0; enTick = 1'b1; step(); enTick = 1'b0;
    chk("R6 gated strobe ignored", ONES);
    // R5 off request between strobes ignored
    wrGate = 1'b1; step();
    chk("R5 no strobe no change", ONES);
    strobe(1'b1);
    chk("R4 turn-off", '0);
    offReq = 1'b0; step();
    chk("R5 on request waits for strobe", '0);
    strobe(1'b0);
    chk("R5 turn-on at strobe", ONES);

    // R9 on-time limit
    onLimit = 8'd3;
    strobe(1'b1);
    strobe(1'b0);
    chk("R9 on after turn-on", ONES);
    strobe(1'b0);
    chk("R9 strobe 1", ONES);
    strobe(1'b0);
    chk("R9 strobe 2", ONES);
    strobe(1'b0);
    chk("R9 expired at strobe 3", '0);
    strobe(1'b0);
    chk("R9 stays off", '0);
    strobe(1'b1);
    chk("R9 off strobe", '0);
    strobe(1'b0);
    chk("R9 re-armed", ONES);
    onLimit = 8'd0;
    for (int k = 0; k < 5; k++) strobe(1'b0);
    chk("R9 no limit", ONES);

    // R8 reset mid-run clears counter
    for (int k = 0; k < 5; k++) cntStep();
    #2 rstN = 1'b0; #1;
    chk("R8 async off", '0);
    step();
    rstN = 1'b1; mCnt = 0;
    grayVal = 4'd1;
    strobe(1'b0);
    chk("R8 count at zero", ONES);
    cntStep();
    chk("R8 count at one", '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule